// File: doc/BRIEF.md
# Configuration Byte with Power-Management Capability Gating

This block holds one 8-bit configuration byte of a PCI-style network controller. The byte mixes several kinds of field. A two-bit LED mode field takes its value from the serial EEPROM autoload bus at reset. A driver-present flag lets software record that its driver is running, and the hardware clears that flag when the host writes the PCI command enables. A wake-output polarity bit and a vital-product-data enable bit are plain read/write bits. Two read-only bits report whether the operational registers are decoded in memory space and in I/O space.

Bit 0 enables power management. It can be written only while the EEPROM programming mode input is all ones. Its value decides what the host sees in the capability list of PCI configuration space. With the bit clear, the list is hidden. With it set, the new-capability status bit, the capability pointer, the capability ID and the next pointer announce a single power-management capability, and the PM registers that follow it are flagged valid.

Top module: `nic_cfg_byte`

## Requirements
- R1: While rst_n is low at a clock edge, the LED field (bits 7:6) loads eeprom_led_mode. Bits 5, 4, 1 and 0 reset to 0. Reset takes priority over a register write in the same cycle.
- R2: A register write (reg_wr_en high at a clock edge) stores reg_wr_data[7:6] as the LED mode, [5] as the driver flag, [4] as the wake polarity and [1] as the VPD enable. The new value is visible on reg_rd_data and the field outputs after that edge.
- R3: reg_rd_data[3] always equals map_mem_i and reg_rd_data[2] always equals map_io_i. Register writes to these two positions have no effect.
- R4: A PCI command write (pci_cmd_wr high) clears the driver flag (bit 5) at that edge if any of pci_cmd_en[0] (I/O enable), [1] (memory enable) or [2] (bus-master enable) is 1. A command write with all three at 0 leaves the flag unchanged.
- R5: If a register write and a driver-flag clear from R4 occur in the same cycle, the flag ends at 0. The other fields of that write are still stored.
- R6: Bit 0 (PM enable) takes reg_wr_data[0] on a register write only when prog_mode is 2'b11. For any other prog_mode value it keeps its previous value.
- R7: While PM enable is 0, new_cap_o, cap_ptr_o, pm_cap_id_o, pm_next_ptr_o and pm_regs_valid_o are all 0.
- R8: While PM enable is 1, new_cap_o is 1, cap_ptr_o is 8'h50, pm_cap_id_o is 8'h01, pm_next_ptr_o is 8'h00 and pm_regs_valid_o is 1.
- R9: led_mode_o, drv_loaded_o, wake_pol_o, vpd_en_o and pm_en_o always equal bits 7:6, 5, 4, 1 and 0 of reg_rd_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eeprom_led_mode | input | 2 | LED mode value from the EEPROM autoload bus |
| map_mem_i | input | 1 | Registers decoded in memory space (status) |
| map_io_i | input | 1 | Registers decoded in I/O space (status) |
| prog_mode | input | 2 | EEPROM programming mode; 2'b11 unlocks PM enable |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Current register value |
| pci_cmd_wr | input | 1 | PCI command register write strobe |
| pci_cmd_en | input | 3 | Command write data: bit 0 I/O, bit 1 memory, bit 2 bus master |
| led_mode_o | output | 2 | LED mode field |
| drv_loaded_o | output | 1 | Driver-present flag |
| wake_pol_o | output | 1 | Wake output polarity, to the wake generator |
| vpd_en_o | output | 1 | Vital product data enable |
| pm_en_o | output | 1 | Power-management enable |
| new_cap_o | output | 1 | New-capability status bit |
| cap_ptr_o | output | 8 | Capability list pointer |
| pm_cap_id_o | output | 8 | PM capability ID |
| pm_next_ptr_o | output | 8 | Next pointer of the PM capability |
| pm_regs_valid_o | output | 1 | PM registers valid |

## Verification
Every stored bit is visible on reg_rd_data one edge after the write or clear that changes it. A wrong driver flag or a broken lock therefore shows on the very next read. A wrong PM enable shows within the same cycle on all five capability outputs at once, because they are decoded combinationally from that one bit. A fault in the reset load shows as a wrong LED field on the first cycle after reset. This is why the checks sample one edge after each stimulus, both for the events that should change state and for those that should not.

// File: rtl/nic_cfg_pkg.sv
// Package: bit positions and capability constants shared by the
// configuration byte and its sub-blocks.
// Assumes: an 8-bit register laid out as LED[7:6], DRV[5], WAKE[4],
// MEM[3], IO[2], VPD[1], PM[0].
package nic_cfg_pkg;
    localparam int REG_W      = 8;
    localparam int LED_W      = 2;
    localparam int CMD_EN_W   = 3;
    localparam int MODE_W     = 2;
    localparam int LED_LSB    = 6;
    localparam int DRV_BIT    = 5;
    localparam int WAKE_BIT   = 4;
    localparam int MEM_BIT    = 3;
    localparam int IO_BIT     = 2;
    localparam int VPD_BIT    = 1;
    localparam int PM_BIT     = 0;

    // Stored writable fields of the configuration byte.
    typedef struct packed {
        logic [LED_W-1:0] led;
        logic             drv;
        logic             wake;
        logic             vpd;
        logic             pm;
    } cfg_fields_t;

    // Capability-list view presented to configuration space.
    typedef struct packed {
        logic       new_cap;
        logic [7:0] cap_ptr;
        logic [7:0] cap_id;
        logic [7:0] next_ptr;
        logic       regs_valid;
    } cap_view_t;
endpackage

// File: rtl/nic_cfg_drvflag.sv
// Module: driver-present flag with hardware self-clear.
// Software sets or clears the flag through the register write port.
// A PCI command write with any enable bit set clears the flag, and that
// clear wins over a simultaneous software write.
// Assumes: synchronous active-low reset, single clock domain.
module nic_cfg_drvflag #(
    parameter int CMD_EN_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_bit,
    input  logic                cmd_wr,
    input  logic [CMD_EN_W-1:0] cmd_en,
    output logic                flag
);
    logic auto_clr;

    // Detect a command write that touches any enable bit.
    always_comb begin
        auto_clr = cmd_wr && (|cmd_en);
    end

    // Update the flag: reset, then hardware clear, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (auto_clr) begin
            flag <= 1'b0;
        end else if (wr_en) begin
            flag <= wr_bit;
        end
    end

    // R5: a hardware clear wins over a simultaneous write
    assert_autoclr_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && (|cmd_en)) |=> !flag);

    // R4: a command write with no enable bit set leaves the flag alone
    assert_noclr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !(|cmd_en) && !wr_en) |=> $stable(flag));
endmodule

// File: rtl/nic_cfg_fields.sv
// Module: writable fields of the configuration byte other than the
// driver flag. The LED field reloads from the EEPROM bus on reset. The PM
// enable accepts writes only in the unlocked programming mode.
// Assumes: synchronous active-low reset; eeprom_led is stable while
// reset is held.
module nic_cfg_fields
    import nic_cfg_pkg::*;
#(
    parameter int                 MODE_WIDTH  = MODE_W,
    parameter logic [MODE_W-1:0]  UNLOCK_CODE = 2'b11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LED_W-1:0]      eeprom_led,
    input  logic [MODE_WIDTH-1:0] prog_mode,
    input  logic                  wr_en,
    input  logic [REG_W-1:0]      wr_data,
    output logic [LED_W-1:0]      led,
    output logic                  wake,
    output logic                  vpd,
    output logic                  pm
);
    logic pm_unlocked;

    // Decode whether the PM enable bit may be written.
    always_comb begin
        pm_unlocked = (prog_mode == UNLOCK_CODE);
    end

    // Plain read/write fields; the LED field takes its EEPROM value on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led  <= eeprom_led;
            wake <= 1'b0;
            vpd  <= 1'b0;
        end else if (wr_en) begin
            led  <= wr_data[LED_LSB +: LED_W];
            wake <= wr_data[WAKE_BIT];
            vpd  <= wr_data[VPD_BIT];
        end
    end

    // PM enable with its write lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pm <= 1'b0;
        end else if (wr_en && pm_unlocked) begin
            pm <= wr_data[PM_BIT];
        end
    end

    // R6: the PM enable cannot change outside the unlock mode
    assert_pm_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_mode != UNLOCK_CODE) |=> $stable(pm));

    // R1: the first cycle after reset shows the EEPROM LED value
    assert_reset_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (led == $past(eeprom_led) && !wake && !vpd && !pm));

    // R2: a write stores the LED field
    assert_led_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (led == $past(wr_data[LED_LSB +: LED_W])));
endmodule

// File: rtl/nic_cfg_capgate.sv
// Module: capability-list gating. It derives the new-capability bit, the
// capability pointer, the PM capability ID and next pointer, and the
// PM-register valid flag from the PM enable bit.
// Assumes: a single PM capability placed at CAP_OFFSET that ends the list.
module nic_cfg_capgate
    import nic_cfg_pkg::*;
#(
    parameter logic [7:0] CAP_OFFSET = 8'h50,
    parameter logic [7:0] CAP_ID     = 8'h01,
    parameter logic [7:0] NEXT_PTR   = 8'h00
) (
    input  logic      pm_en,
    output cap_view_t view
);
    // Show the capability when enabled and hide every field otherwise.
    always_comb begin
        if (pm_en) begin
            view.new_cap    = 1'b1;
            view.cap_ptr    = CAP_OFFSET;
            view.cap_id     = CAP_ID;
            view.next_ptr   = NEXT_PTR;
            view.regs_valid = 1'b1;
        end else begin
            view = '0;
        end
    end
endmodule

// File: rtl/nic_cfg_byte.sv
// Module: top of the configuration byte. It assembles the stored fields
// and the read-only mapping status into the register read value, and
// exposes the field and capability outputs.
// Assumes: synchronous active-low reset; reads are combinational.
module nic_cfg_byte
    import nic_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LED_W-1:0]    eeprom_led_mode,
    input  logic                map_mem_i,
    input  logic                map_io_i,
    input  logic [MODE_W-1:0]   prog_mode,
    input  logic                reg_wr_en,
    input  logic [REG_W-1:0]    reg_wr_data,
    output logic [REG_W-1:0]    reg_rd_data,
    input  logic                pci_cmd_wr,
    input  logic [CMD_EN_W-1:0] pci_cmd_en,
    output logic [LED_W-1:0]    led_mode_o,
    output logic                drv_loaded_o,
    output logic                wake_pol_o,
    output logic                vpd_en_o,
    output logic                pm_en_o,
    output logic                new_cap_o,
    output logic [7:0]          cap_ptr_o,
    output logic [7:0]          pm_cap_id_o,
    output logic [7:0]          pm_next_ptr_o,
    output logic                pm_regs_valid_o
);
    localparam logic [7:0] PM_CAP_OFFSET = 8'h50;
    localparam logic [7:0] PM_CAP_ID     = 8'h01;

    cfg_fields_t f;
    cap_view_t   cv;

    nic_cfg_drvflag #(.CMD_EN_W(CMD_EN_W)) u_drv (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .wr_bit (reg_wr_data[DRV_BIT]),
        .cmd_wr (pci_cmd_wr),
        .cmd_en (pci_cmd_en),
        .flag   (f.drv)
    );

    nic_cfg_fields u_fields (
        .clk        (clk),
        .rst_n      (rst_n),
        .eeprom_led (eeprom_led_mode),
        .prog_mode  (prog_mode),
        .wr_en      (reg_wr_en),
        .wr_data    (reg_wr_data),
        .led        (f.led),
        .wake       (f.wake),
        .vpd        (f.vpd),
        .pm         (f.pm)
    );

    nic_cfg_capgate #(
        .CAP_OFFSET (PM_CAP_OFFSET),
        .CAP_ID     (PM_CAP_ID),
        .NEXT_PTR   (8'h00)
    ) u_cap (
        .pm_en (f.pm),
        .view  (cv)
    );

    // Assemble the register read value from the fields and the status inputs.
    always_comb begin
        reg_rd_data                      = '0;
        reg_rd_data[LED_LSB +: LED_W]    = f.led;
        reg_rd_data[DRV_BIT]             = f.drv;
        reg_rd_data[WAKE_BIT]            = f.wake;
        reg_rd_data[MEM_BIT]             = map_mem_i;
        reg_rd_data[IO_BIT]              = map_io_i;
        reg_rd_data[VPD_BIT]             = f.vpd;
        reg_rd_data[PM_BIT]              = f.pm;
    end

    // Drive the field and capability outputs.
    always_comb begin
        led_mode_o      = f.led;
        drv_loaded_o    = f.drv;
        wake_pol_o      = f.wake;
        vpd_en_o        = f.vpd;
        pm_en_o         = f.pm;
        new_cap_o       = cv.new_cap;
        cap_ptr_o       = cv.cap_ptr;
        pm_cap_id_o     = cv.cap_id;
        pm_next_ptr_o   = cv.next_ptr;
        pm_regs_valid_o = cv.regs_valid;
    end

    // R8: an unlocked write of 1 to PM enable exposes the capability
    assert_cap_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_data[PM_BIT] && prog_mode == 2'b11) |=>
        (new_cap_o && cap_ptr_o == PM_CAP_OFFSET && pm_cap_id_o == PM_CAP_ID
         && pm_next_ptr_o == 8'h00 && pm_regs_valid_o));

    // R7: an unlocked write of 0 to PM enable hides the capability
    assert_cap_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !reg_wr_data[PM_BIT] && prog_mode == 2'b11) |=>
        (!new_cap_o && cap_ptr_o == 8'h00 && pm_cap_id_o == 8'h00
         && pm_next_ptr_o == 8'h00 && !pm_regs_valid_o));

    // R2: a write without a command clear stores the driver flag
    assert_drv_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !pci_cmd_wr) |=> (drv_loaded_o == $past(reg_wr_data[DRV_BIT])));
endmodule

// File: tb/tb_nic_cfg_byte.sv
// Directed bench for nic_cfg_byte: one task per scenario.
module tb_nic_cfg_byte;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] eeprom_led_mode;
    logic       map_mem_i, map_io_i;
    logic [1:0] prog_mode;
    logic       reg_wr_en;
    logic [7:0] reg_wr_data, reg_rd_data;
    logic       pci_cmd_wr;
    logic [2:0] pci_cmd_en;
    logic [1:0] led_mode_o;
    logic       drv_loaded_o, wake_pol_o, vpd_en_o, pm_en_o, new_cap_o, pm_regs_valid_o;
    logic [7:0] cap_ptr_o, pm_cap_id_o, pm_next_ptr_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    nic_cfg_byte dut (
        .clk(clk), .rst_n(rst_n), .eeprom_led_mode(eeprom_led_mode),
        .map_mem_i(map_mem_i), .map_io_i(map_io_i), .prog_mode(prog_mode),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .pci_cmd_wr(pci_cmd_wr), .pci_cmd_en(pci_cmd_en),
        .led_mode_o(led_mode_o), .drv_loaded_o(drv_loaded_o), .wake_pol_o(wake_pol_o),
        .vpd_en_o(vpd_en_o), .pm_en_o(pm_en_o), .new_cap_o(new_cap_o),
        .cap_ptr_o(cap_ptr_o), .pm_cap_id_o(pm_cap_id_o), .pm_next_ptr_o(pm_next_ptr_o),
        .pm_regs_valid_o(pm_regs_valid_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus at the falling edge; results are sampled after the next rising edge.
    task automatic cycle(input logic we, input logic [7:0] wd, input logic cw, input logic [2:0] ce);
        @(negedge clk);
        reg_wr_en = we; reg_wr_data = wd; pci_cmd_wr = cw; pci_cmd_en = ce;
        @(posedge clk);
        #1;
        reg_wr_en = 1'b0; pci_cmd_wr = 1'b0; pci_cmd_en = 3'b000;
    endtask

    task automatic check_cap(input string req, input logic on);
        check(req, {new_cap_o, cap_ptr_o, pm_cap_id_o, pm_next_ptr_o, pm_regs_valid_o},
              on ? {1'b1, 8'h50, 8'h01, 8'h00, 1'b1} : 26'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; eeprom_led_mode = 2'b10; map_mem_i = 1'b1; map_io_i = 1'b0;
        prog_mode = 2'b11;
        cycle(1'b1, 8'hFF, 1'b0, 3'b000);
        cycle(1'b1, 8'hFF, 1'b0, 3'b000);
        // R1: reset wins over a write; LED field from EEPROM, others 0
        check("R1 reset value", reg_rd_data, 8'h88);
        @(negedge clk); rst_n = 1'b1;
        cycle(1'b0, 8'h00, 1'b0, 3'b000);
        check("R1 after release", reg_rd_data, 8'h88);
        check_cap("R7 cap hidden after reset", 1'b0);
    endtask

    task automatic t_rw();
        prog_mode = 2'b00;
        cycle(1'b1, 8'hFF, 1'b0, 3'b000);
        check("R2 write ones", reg_rd_data, 8'hFA);
        check("R9 field outputs", {led_mode_o, drv_loaded_o, wake_pol_o, vpd_en_o, pm_en_o}, 6'b111110);
        check("R6 PM locked", pm_en_o, 1'b0);
        cycle(1'b1, 8'h4C, 1'b0, 3'b000);
        check("R2 R3 write pattern", reg_rd_data, 8'h48);
        cycle(1'b1, 8'h00, 1'b0, 3'b000);
        check("R2 write zeros", reg_rd_data, 8'h08);
    endtask

    task automatic t_map();
        @(negedge clk); map_mem_i = 1'b0; map_io_i = 1'b1; #1;
        check("R3 status bits follow inputs", reg_rd_data[3:2], 2'b01);
        cycle(1'b1, 8'h08, 1'b0, 3'b000);
        check("R3 write ignored", reg_rd_data, 8'h04);
    endtask

    task automatic t_pm();
        prog_mode = 2'b11;
        cycle(1'b1, 8'h01, 1'b0, 3'b000);
        check("R6 unlocked write", pm_en_o, 1'b1);
        check_cap("R8 cap shown", 1'b1);
        prog_mode = 2'b01;
        cycle(1'b1, 8'h00, 1'b0, 3'b000);
        check("R6 locked write mode 01", pm_en_o, 1'b1);
        check_cap("R8 cap still shown", 1'b1);
        prog_mode = 2'b10;
        cycle(1'b1, 8'h00, 1'b0, 3'b000);
        check("R6 locked write mode 10", pm_en_o, 1'b1);
        prog_mode = 2'b11;
        cycle(1'b1, 8'h00, 1'b0, 3'b000);
        check("R6 unlocked clear", pm_en_o, 1'b0);
        check_cap("R7 cap hidden", 1'b0);
    endtask

    task automatic t_autoclr();
        cycle(1'b1, 8'h20, 1'b0, 3'b000);
        check("R2 drv set", drv_loaded_o, 1'b1);
        cycle(1'b0, 8'h00, 1'b1, 3'b000);
        check("R4 cmd write without enables", drv_loaded_o, 1'b1);
        cycle(1'b0, 8'h00, 1'b1, 3'b100);
        check("R4 bus-master clear", drv_loaded_o, 1'b0);
        cycle(1'b1, 8'h20, 1'b0, 3'b000);
        cycle(1'b0, 8'h00, 1'b1, 3'b001);
        check("R4 io clear", drv_loaded_o, 1'b0);
        cycle(1'b1, 8'h20, 1'b0, 3'b000);
        cycle(1'b0, 8'h20, 1'b0, 3'b010);
        check("R4 strobe low no clear", drv_loaded_o, 1'b1);
        cycle(1'b0, 8'h00, 1'b1, 3'b010);
        check("R4 mem clear", drv_loaded_o, 1'b0);
    endtask

    task automatic t_race();
        cycle(1'b1, 8'h72, 1'b1, 3'b010);
        // R5: clear wins on bit 5, other fields stored (01_0_1_01_1_0 with map 01)
        check("R5 clear wins", reg_rd_data, 8'h56);
    endtask

    initial begin
        rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_data = '0; pci_cmd_wr = 1'b0;
        pci_cmd_en = '0; prog_mode = '0; eeprom_led_mode = '0;
        map_mem_i = 1'b0; map_io_i = 1'b0;
        t_reset();
        t_rw();
        t_map();
        t_pm();
        t_autoclr();
        t_race();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule